// File: doc/BRIEF.md
# Endpoint Bank Controller

This block keeps the ownership book for the multi-bank buffer of one device endpoint, seen from the firmware side. It keeps two bank pointers: one for the processor side and one for the line side. Both wrap modulo the bank count. It also keeps a busy-bank count and a buffer-ownership flag (`fifo_ctl`) that passes banks between software and the line. For IN endpoints, software fills the bank it owns and releases it with `fifo_rel`, and the line side sends committed banks. For OUT endpoints, the line side fills banks and software drains and releases them. Control endpoints never own banks through this flag.

For IN endpoints, software can ask to throw away the bank it committed most recently (`kill_req`). The request is refused when that bank is the one the line is sending. Interrupt enables change only through write-one-to-set and write-one-to-clear strobes. Four sticky status flags and one level flag (banks busy) are gated by those enables into a single interrupt line.

Bus events reach the block as one-cycle pulses: IN token seen, transmission finished, OUT bank received. No data passes through the block, so it has no valid/ready interface and no back-pressure rules. Every pin is a plain level or a one-cycle strobe. `ep_kind` must only change while `rst_n` is low.

Top module: `ep_bank_ctrl`

## Requirements
- R1: While `rst_n` is low, the following all read 0: `busy_cnt`, both bank pointers, `fifo_ctl`, `rw_ok`, `txin_flag`, `rxout_flag`, `kill_pend`, `ien`, `flags` and `irq`.
- R2: Enable bit order is 0 overflow, 1 stalled, 2 CRC error, 3 short packet, 4 busy banks. A 1 on `ien_set[i]` sets `ien[i]` on the next edge. A 1 on `ien_clr[i]` clears it on the next edge. If both are 1 in the same cycle, clear wins. With neither strobe, the bit holds.
- R3: `flags[3:0]` use the same bit order. Each is sticky. It is set by `evt_set[i]` and cleared by `evt_clr[i]`, and set wins. Bit 0 is also set by an OUT reception that arrives while all banks are busy. `flags[4]` is 1 exactly when `busy_cnt` is nonzero.
- R4: `irq` is the OR over all five bits of `flags & ien`, with no added delay.
- R5: For an IN endpoint, `fifo_ctl` and `txin_flag` both rise on the edge after a cycle in which `fifo_ctl` is 0 and `busy_cnt` is below the bank count. A `fifo_rel` while `fifo_ctl` is 1 does three things on the next edge: it increments `busy_cnt`, advances `cpu_bank` modulo the bank count, and clears `fifo_ctl`.
- R6: For an IN endpoint, `in_token` starts a transfer if no transfer is active and at least one bank that is not being discarded is busy. `tx_done` during an active transfer decrements `busy_cnt` and advances `usb_bank`. `tx_done` with no active transfer is ignored.
- R7: For an OUT endpoint, `rx_done` with `busy_cnt` below the bank count increments `busy_cnt` and advances `usb_bank`. `fifo_ctl` and `rxout_flag` rise on the edge after a cycle in which `fifo_ctl` is 0 and `busy_cnt` is nonzero. `fifo_rel` while `fifo_ctl` is 1 decrements `busy_cnt`, advances `cpu_bank` and clears `fifo_ctl`.
- R8: For a control endpoint (`ep_kind` 0 or 3), `fifo_ctl` and `rw_ok` read 0. In that case `fifo_rel`, `rx_done`, `tx_done`, `in_token` and `kill_req` leave `busy_cnt` and both pointers unchanged.
- R9: On an IN endpoint, `kill_req` raises `kill_pend` on the next edge. It is ignored on other endpoint kinds and while `kill_pend` is 1.
- R10: The request is judged in the first cycle that `kill_pend` is 1. If `busy_cnt` is 0, or if `busy_cnt` is 1 while `in_token` is high or a transfer is active, `kill_pend` falls on the next edge and `busy_cnt` is unchanged.
- R11: Otherwise the request is accepted. On the edge after that, `busy_cnt` drops by one, `cpu_bank` steps back by one, and `kill_pend` falls. A transfer that is already active finishes normally.
- R12: `fifo_rel` is ignored while `kill_pend` is 1. `flag_ack` clears `txin_flag` and `rxout_flag`, unless hardware sets the flag in the same cycle.
- R13: `busy_cnt` never exceeds the bank count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_kind | input | 2 | 0 control, 1 IN, 2 OUT, 3 treated as control |
| ien_set | input | 5 | Enable set strobes |
| ien_clr | input | 5 | Enable clear strobes |
| evt_set | input | 4 | Sticky status set pulses |
| evt_clr | input | 4 | Sticky status clear strobes |
| kill_req | input | 1 | Request to discard the last committed IN bank |
| fifo_rel | input | 1 | Software releases the bank it owns |
| flag_ack | input | 1 | Clears the TX-ready and RX-received flags |
| in_token | input | 1 | IN token seen on the line |
| tx_done | input | 1 | Current IN bank fully sent |
| rx_done | input | 1 | OUT bank fully received |
| cpu_bank | output | PW | Bank index the processor side uses |
| usb_bank | output | PW | Bank index the line side uses |
| busy_cnt | output | CW | Number of busy banks |
| fifo_ctl | output | 1 | Software owns the current bank |
| rw_ok | output | 1 | Current bank may be read or written |
| txin_flag | output | 1 | IN bank free for filling |
| rxout_flag | output | 1 | OUT bank filled |
| kill_pend | output | 1 | Discard request in progress |
| ien | output | 5 | Interrupt enables |
| flags | output | 5 | Status flags |
| irq | output | 1 | Gated interrupt |

## Verification
Two functions can fall in the same cycle: judging a discard request, and the line side starting or finishing a transfer. The bench drives `in_token` in exactly the cycle an armed request is judged. It does this once with one committed bank, where the request must be refused, and once with two, where it must be accepted. In the accepted case it then finishes the transfer. The result is judged from `busy_cnt`, both pointers and the fall of `kill_pend`, checked against counts worked out by hand. A random OUT phase releases and receives banks in the same cycle, and compares every cycle against a model built from the requirements.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;
  localparam int IRQ_W    = 5;
  localparam int STICKY_W = 4;
  localparam int FLG_OVF   = 0;
  localparam int FLG_STALL = 1;
  localparam int FLG_CRC   = 2;
  localparam int FLG_SHORT = 3;
  localparam int FLG_BUSY  = 4;

  typedef enum logic [1:0] {
    KIND_CTRL = 2'd0,
    KIND_IN   = 2'd1,
    KIND_OUT  = 2'd2,
    KIND_RSVD = 2'd3
  } ep_kind_e;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_ARMED = 2'd1,
    KS_EXEC  = 2'd2
  } kill_state_e;
endpackage

// File: rtl/ep_irq_unit.sv
module ep_irq_unit #(
  parameter int IRQ_W    = 5,
  parameter int STICKY_W = 4,
  localparam int LVL_W   = IRQ_W - STICKY_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IRQ_W-1:0]    ien_set,
  input  logic [IRQ_W-1:0]    ien_clr,
  input  logic [STICKY_W-1:0] sticky_set,
  input  logic [STICKY_W-1:0] sticky_clr,
  input  logic [LVL_W-1:0]    level_in,
  output logic [IRQ_W-1:0]    ien_q,
  output logic [IRQ_W-1:0]    flags,
  output logic                irq
);
  logic [STICKY_W-1:0] sticky_q;

  // one enable register per source; clear has priority over set
  for (genvar g = 0; g < IRQ_W; g++) begin : g_en
    always_ff @(posedge clk) begin
      if (!rst_n)          ien_q[g] <= 1'b0;
      else if (ien_clr[g]) ien_q[g] <= 1'b0;
      else if (ien_set[g]) ien_q[g] <= 1'b1;
    end
  end

  // sticky status: a new event beats a software clear
  for (genvar g = 0; g < STICKY_W; g++) begin : g_st
    always_ff @(posedge clk) begin
      if (!rst_n)             sticky_q[g] <= 1'b0;
      else if (sticky_set[g]) sticky_q[g] <= 1'b1;
      else if (sticky_clr[g]) sticky_q[g] <= 1'b0;
    end
  end

  assign flags = {level_in, sticky_q};
  assign irq   = |(flags & ien_q);
endmodule

// File: rtl/ep_kill_unit.sv
module ep_kill_unit
  import ep_bank_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_in,
  input  logic          kill_req,
  input  logic [CW-1:0] busy_cnt,
  input  logic          in_token,
  input  logic          tx_active,
  output logic          kill_pend,
  output logic          kill_discard
);
  kill_state_e st_q, st_d;
  logic        collide;

  // the only busy bank is the one on the line (or about to be)
  assign collide = (busy_cnt == CW'(1)) && (in_token || tx_active);

  always_comb begin
    st_d = st_q;
    case (st_q)
      KS_IDLE:  if (is_in && kill_req) st_d = KS_ARMED;
      KS_ARMED: begin
        if (busy_cnt == '0 || collide) st_d = KS_IDLE;
        else                           st_d = KS_EXEC;
      end
      KS_EXEC:  st_d = KS_IDLE;
      default:  st_d = KS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign kill_pend    = (st_q != KS_IDLE);
  assign kill_discard = (st_q == KS_EXEC);
endmodule

// File: rtl/ep_bank_track.sv
module ep_bank_track
  import ep_bank_pkg::*;
#(
  parameter int NB = 2,
  localparam int PW = (NB > 1) ? $clog2(NB) : 1,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    kind,
  input  logic          rel,
  input  logic          flag_ack,
  input  logic          in_token,
  input  logic          tx_done,
  input  logic          rx_done,
  input  logic          kill_pend,
  input  logic          kill_discard,
  output logic [PW-1:0] cpu_ptr,
  output logic [PW-1:0] usb_ptr,
  output logic [CW-1:0] busy_cnt,
  output logic          own_q,
  output logic          txin_q,
  output logic          rxout_q,
  output logic          tx_active,
  output logic          ovf_pulse
);
  function automatic logic [PW-1:0] ptr_fwd(input logic [PW-1:0] p);
    return (p == PW'(NB - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] ptr_back(input logic [PW-1:0] p);
    return (p == '0) ? PW'(NB - 1) : p - 1'b1;
  endfunction

  logic is_in, is_out;
  logic rel_ok, disc, tx_start, tx_fin, rx_take;
  logic inc, dec_a, dec_b;
  logic own_set, busy_full, busy_any;
  logic [CW-1:0] busy_eff, busy_d;
  logic [PW-1:0] cpu_d, usb_d;
  int   sum;

  assign is_in  = (kind == KIND_IN);
  assign is_out = (kind == KIND_OUT);

  assign busy_full = (busy_cnt >= CW'(NB));
  assign busy_any  = (busy_cnt != '0);

  assign rel_ok   = own_q && rel && !kill_pend;
  assign disc     = is_in && kill_discard;
  assign busy_eff = busy_cnt - {{(CW-1){1'b0}}, disc};
  assign tx_start = is_in && in_token && !tx_active && (busy_eff != '0);
  assign tx_fin   = is_in && tx_done && tx_active;
  assign rx_take  = is_out && rx_done && !busy_full;
  assign ovf_pulse = is_out && rx_done && busy_full;

  assign inc   = (is_in && rel_ok) || rx_take;
  assign dec_a = tx_fin || (is_out && rel_ok);
  assign dec_b = disc;

  // saturating count update
  always_comb begin
    sum = int'(busy_cnt) + int'(inc) - int'(dec_a) - int'(dec_b);
    if (sum < 0)       sum = 0;
    else if (sum > NB) sum = NB;
    busy_d = CW'(sum);
  end

  always_comb begin
    cpu_d = cpu_ptr;
    if (rel_ok)    cpu_d = ptr_fwd(cpu_ptr);
    else if (disc) cpu_d = ptr_back(cpu_ptr);
    usb_d = (tx_fin || rx_take) ? ptr_fwd(usb_ptr) : usb_ptr;
  end

  // ownership returns to software when a free (IN) or filled (OUT) bank waits
  assign own_set = !own_q && ((is_in && !busy_full) || (is_out && busy_any));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt  <= '0;
      cpu_ptr   <= '0;
      usb_ptr   <= '0;
      own_q     <= 1'b0;
      txin_q    <= 1'b0;
      rxout_q   <= 1'b0;
      tx_active <= 1'b0;
    end else begin
      busy_cnt <= busy_d;
      cpu_ptr  <= cpu_d;
      usb_ptr  <= usb_d;
      if (own_q) own_q <= !rel_ok && (is_in || is_out);
      else       own_q <= own_set;
      txin_q  <= (is_in && own_set) || (txin_q && !flag_ack);
      rxout_q <= (is_out && own_set) || (rxout_q && !flag_ack);
      if (tx_start)    tx_active <= 1'b1;
      else if (tx_fin) tx_active <= 1'b0;
    end
  end
endmodule

// File: rtl/ep_bank_ctrl.sv
module ep_bank_ctrl
  import ep_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int PW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CW = $clog2(NUM_BANKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ep_kind,
  input  logic [4:0]    ien_set,
  input  logic [4:0]    ien_clr,
  input  logic [3:0]    evt_set,
  input  logic [3:0]    evt_clr,
  input  logic          kill_req,
  input  logic          fifo_rel,
  input  logic          flag_ack,
  input  logic          in_token,
  input  logic          tx_done,
  input  logic          rx_done,
  output logic [PW-1:0] cpu_bank,
  output logic [PW-1:0] usb_bank,
  output logic [CW-1:0] busy_cnt,
  output logic          fifo_ctl,
  output logic          rw_ok,
  output logic          txin_flag,
  output logic          rxout_flag,
  output logic          kill_pend,
  output logic [4:0]    ien,
  output logic [4:0]    flags,
  output logic          irq
);
  logic kill_discard, tx_active, ovf_pulse;
  logic [STICKY_W-1:0] sticky_set;

  ep_kill_unit #(.CW(CW)) u_kill (
    .clk          (clk),
    .rst_n        (rst_n),
    .is_in        (ep_kind == KIND_IN),
    .kill_req     (kill_req),
    .busy_cnt     (busy_cnt),
    .in_token     (in_token),
    .tx_active    (tx_active),
    .kill_pend    (kill_pend),
    .kill_discard (kill_discard)
  );

  ep_bank_track #(.NB(NUM_BANKS)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .kind         (ep_kind),
    .rel          (fifo_rel),
    .flag_ack     (flag_ack),
    .in_token     (in_token),
    .tx_done      (tx_done),
    .rx_done      (rx_done),
    .kill_pend    (kill_pend),
    .kill_discard (kill_discard),
    .cpu_ptr      (cpu_bank),
    .usb_ptr      (usb_bank),
    .busy_cnt     (busy_cnt),
    .own_q        (fifo_ctl),
    .txin_q       (txin_flag),
    .rxout_q      (rxout_flag),
    .tx_active    (tx_active),
    .ovf_pulse    (ovf_pulse)
  );

  assign sticky_set = evt_set | {{(STICKY_W-1){1'b0}}, ovf_pulse};

  ep_irq_unit #(.IRQ_W(IRQ_W), .STICKY_W(STICKY_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ien_set    (ien_set),
    .ien_clr    (ien_clr),
    .sticky_set (sticky_set),
    .sticky_clr (evt_clr),
    .level_in   (busy_cnt != '0),
    .ien_q      (ien),
    .flags      (flags),
    .irq        (irq)
  );

  assign rw_ok = fifo_ctl;
endmodule

// File: rtl/ep_bank_ctrl_chk.sv
module ep_bank_ctrl_chk #(
  parameter int NUM_BANKS = 2,
  localparam int PW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CW = $clog2(NUM_BANKS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    ep_kind,
  input logic [4:0]    ien_set,
  input logic [4:0]    ien_clr,
  input logic [3:0]    evt_set,
  input logic [3:0]    evt_clr,
  input logic          kill_req,
  input logic          fifo_rel,
  input logic          flag_ack,
  input logic          in_token,
  input logic          tx_done,
  input logic          rx_done,
  input logic [PW-1:0] cpu_bank,
  input logic [PW-1:0] usb_bank,
  input logic [CW-1:0] busy_cnt,
  input logic          fifo_ctl,
  input logic          rw_ok,
  input logic          txin_flag,
  input logic          rxout_flag,
  input logic          kill_pend,
  input logic [4:0]    ien,
  input logic [4:0]    flags,
  input logic          irq
);
  initial begin
    param_range_chk: assert (NUM_BANKS >= 1 && NUM_BANKS <= 3);
  end

  // R13
  busy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CW'(NUM_BANKS));

  // R8
  ctrl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_kind == 2'd0 || ep_kind == 2'd3) |-> (!fifo_ctl && !rw_ok));

  // R2
  ien_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_clr != '0) |=> ((ien & $past(ien_clr)) == '0));

  // R2
  ien_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ien_set & ~ien_clr) != '0) |=>
      ((ien & $past(ien_set & ~ien_clr)) == $past(ien_set & ~ien_clr)));

  // R5
  own_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_ctl) |-> (txin_flag || rxout_flag));

  // R11
  kill_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_pend && $past(kill_pend)) |=> !kill_pend);

  // R4
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

  // R7
  out_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_kind == 2'd2 && rx_done && busy_cnt == CW'(NUM_BANKS)) |=> flags[0]);
endmodule

bind ep_bank_ctrl ep_bank_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/ep_bank_ctrl_test.sv
module ep_bank_ctrl_test;
  localparam int NB = 2;
  localparam int PW = 1;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    ep_kind = 2'd1;
  logic [4:0]    ien_set = '0, ien_clr = '0;
  logic [3:0]    evt_set = '0, evt_clr = '0;
  logic          kill_req = 1'b0, fifo_rel = 1'b0, flag_ack = 1'b0;
  logic          in_token = 1'b0, tx_done = 1'b0, rx_done = 1'b0;
  logic [PW-1:0] cpu_bank, usb_bank;
  logic [CW-1:0] busy_cnt;
  logic          fifo_ctl, rw_ok, txin_flag, rxout_flag, kill_pend, irq;
  logic [4:0]    ien, flags;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  ep_bank_ctrl #(.NUM_BANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .ep_kind(ep_kind),
    .ien_set(ien_set), .ien_clr(ien_clr), .evt_set(evt_set), .evt_clr(evt_clr),
    .kill_req(kill_req), .fifo_rel(fifo_rel), .flag_ack(flag_ack),
    .in_token(in_token), .tx_done(tx_done), .rx_done(rx_done),
    .cpu_bank(cpu_bank), .usb_bank(usb_bank), .busy_cnt(busy_cnt),
    .fifo_ctl(fifo_ctl), .rw_ok(rw_ok), .txin_flag(txin_flag),
    .rxout_flag(rxout_flag), .kill_pend(kill_pend),
    .ien(ien), .flags(flags), .irq(irq)
  );

  function automatic int ring_next(input int p);
    return (p == NB - 1) ? 0 : p + 1;
  endfunction

  function automatic int clamp_busy(input int b);
    return (b < 0) ? 0 : ((b > NB) ? NB : b);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic drop_all();
    ien_set = '0; ien_clr = '0; evt_set = '0; evt_clr = '0;
    kill_req = 0; fifo_rel = 0; flag_ack = 0;
    in_token = 0; tx_done = 0; rx_done = 0;
  endtask

  task automatic do_reset(input logic [1:0] k);
    drop_all();
    rst_n = 0; ep_kind = k;
    cyc(3);
    rst_n = 1;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // ---------------- IN endpoint ----------------
    drop_all();
    rst_n = 0; ep_kind = 2'd1;
    cyc(3);
    // R1 reset state
    chk("R1", "busy", int'(busy_cnt), 0);
    chk("R1", "cpu", int'(cpu_bank), 0);
    chk("R1", "usb", int'(usb_bank), 0);
    chk("R1", "own", int'(fifo_ctl), 0);
    chk("R1", "ien/flags/irq", int'({ien, flags, irq, kill_pend, txin_flag}), 0);
    rst_n = 1;
    cyc();
    // R5 ownership appears with tx-ready flag
    chk("R5", "own after reset", int'(fifo_ctl), 1);
    chk("R5", "txin", int'(txin_flag), 1);

    // R2 clear wins over set
    ien_set = 5'h1F; ien_clr = 5'h01;
    cyc(); drop_all();
    chk("R2", "ien both", int'(ien), 5'h1E);

    // kill on empty endpoint
    kill_req = 1; cyc(); drop_all();
    chk("R9", "pend", int'(kill_pend), 1);
    cyc();
    chk("R10", "empty pend", int'(kill_pend), 0);
    chk("R10", "empty busy", int'(busy_cnt), 0);

    // commit one bank, acknowledge flag in the same cycle
    fifo_rel = 1; flag_ack = 1; cyc(); drop_all();
    chk("R5", "commit busy", int'(busy_cnt), 1);
    chk("R5", "commit cpu", int'(cpu_bank), 1);
    chk("R5", "commit own", int'(fifo_ctl), 0);
    chk("R12", "ack txin", int'(txin_flag), 0);
    chk("R4", "irq busy", int'(irq), 1);
    cyc();
    chk("R12", "txin reset by hw", int'(txin_flag), 1);

    // kill with one ready bank, idle line; release and re-kill while pending
    kill_req = 1; cyc(); drop_all();
    fifo_rel = 1; kill_req = 1; cyc(); drop_all();
    chk("R12", "release blocked busy", int'(busy_cnt), 1);
    chk("R12", "release blocked cpu", int'(cpu_bank), 1);
    chk("R11", "pend exec", int'(kill_pend), 1);
    cyc();
    chk("R11", "discard busy", int'(busy_cnt), 0);
    chk("R11", "discard cpu", int'(cpu_bank), 0);
    chk("R11", "discard pend", int'(kill_pend), 0);
    cyc();
    chk("R9", "no rearm", int'(kill_pend), 0);

    // kill with one ready bank, token arrives at judgement: refused
    fifo_rel = 1; cyc(); drop_all(); cyc();
    kill_req = 1; cyc(); drop_all();
    in_token = 1; cyc(); drop_all();
    chk("R10", "refused pend", int'(kill_pend), 0);
    chk("R10", "refused busy", int'(busy_cnt), 1);
    tx_done = 1; cyc(); drop_all();
    chk("R6", "sent busy", int'(busy_cnt), 0);
    chk("R6", "sent usb", int'(usb_bank), 1);
    tx_done = 1; cyc(); drop_all();
    chk("R6", "stray done usb", int'(usb_bank), 1);

    // two ready banks, token at judgement: accepted
    fifo_rel = 1; cyc(); drop_all(); cyc();
    fifo_rel = 1; cyc(); drop_all(); cyc();
    chk("R5", "full own", int'(fifo_ctl), 0);
    chk("R13", "full busy", int'(busy_cnt), 2);
    kill_req = 1; cyc(); drop_all();
    in_token = 1; cyc(); drop_all();
    chk("R11", "two pend", int'(kill_pend), 1);
    cyc();
    chk("R11", "two busy", int'(busy_cnt), 1);
    chk("R11", "two cpu back", int'(cpu_bank), 0);
    chk("R11", "two pend off", int'(kill_pend), 0);
    tx_done = 1; cyc(); drop_all();
    chk("R11", "transfer kept busy", int'(busy_cnt), 0);
    chk("R6", "transfer usb", int'(usb_bank), 0);

    // ---------------- control endpoint ----------------
    do_reset(2'd0);
    cyc();
    fifo_rel = 1; rx_done = 1; in_token = 1; kill_req = 1; tx_done = 1;
    cyc(3); drop_all();
    chk("R8", "ctrl own", int'(fifo_ctl), 0);
    chk("R8", "ctrl rw", int'(rw_ok), 0);
    chk("R8", "ctrl busy", int'(busy_cnt), 0);
    chk("R8", "ctrl ptrs", int'({cpu_bank, usb_bank, kill_pend}), 0);

    // ---------------- OUT endpoint, random ----------------
    do_reset(2'd2);
    cyc();
    chk("R7", "out idle own", int'(fifo_ctl), 0);
    begin
      int m_busy, m_cpu, m_usb, m_fc, m_rx;
      logic [3:0] m_st;
      logic [4:0] m_ien, m_flags;
      m_busy = 0; m_cpu = 0; m_usb = 0; m_fc = 0; m_rx = 0;
      m_st = '0; m_ien = ien;
      for (int i = 0; i < 400; i++) begin
        logic rel_ok, take, ovf, fset;
        ien_set  = 5'($urandom_range(0, 31)) & 5'($urandom_range(0, 31));
        ien_clr  = 5'($urandom_range(0, 31)) & 5'($urandom_range(0, 31)) & 5'($urandom_range(0, 31));
        evt_set  = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
        evt_clr  = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
        rx_done  = ($urandom_range(0, 9) < 4);
        fifo_rel = ($urandom_range(0, 9) < 4);
        flag_ack = ($urandom_range(0, 9) < 3);
        kill_req = ($urandom_range(0, 9) < 2);
        in_token = ($urandom_range(0, 9) < 2);
        tx_done  = ($urandom_range(0, 9) < 2);
        rel_ok = (m_fc != 0) && fifo_rel;
        take   = rx_done && (m_busy < NB);
        ovf    = rx_done && (m_busy == NB);
        fset   = (m_fc == 0) && (m_busy != 0);
        m_fc   = m_fc ? int'(!rel_ok) : int'(fset);
        m_rx   = int'(fset || (m_rx != 0 && !flag_ack));
        if (rel_ok) m_cpu = ring_next(m_cpu);
        if (take)   m_usb = ring_next(m_usb);
        m_busy = clamp_busy(m_busy + int'(take) - int'(rel_ok));
        m_ien  = (m_ien | ien_set) & ~ien_clr;
        m_st   = (m_st & ~evt_clr) | evt_set | {3'b000, ovf};
        m_flags = {(m_busy != 0), m_st};
        cyc(); drop_all();
        chk("R7", "busy", int'(busy_cnt), m_busy);
        chk("R7", "cpu", int'(cpu_bank), m_cpu);
        chk("R7", "usb", int'(usb_bank), m_usb);
        chk("R7", "own", int'(fifo_ctl), m_fc);
        chk("R12", "rxout", int'(rxout_flag), m_rx);
        chk("R2", "ien", int'(ien), int'(m_ien));
        chk("R3", "flags", int'(flags), int'(m_flags));
        chk("R4", "irq", int'(irq), int'(|(m_flags & m_ien)));
        chk("R9", "out no kill", int'(kill_pend), 0);
      end
    end

    summary();
    $finish;
  end
endmodule